// File: doc/BRIEF.md
# SDRAM Command Sequencer

This block drives the command pins, bank address and multiplexed address bus of a four-bank SDRAM. After reset it holds the chip select high through a power-up wait. It then runs the start-up sequence: one all-bank precharge, a fixed number of auto-refresh commands, and a mode-register load. Once that sequence is done it serves single-beat read and write requests from a request/acknowledge port. For each request it opens the row, issues the column access with auto precharge, and waits until the bank is closed again before it accepts more work. An interval timer raises a refresh request on a fixed period. A pending refresh is served ahead of any user request.

Every minimum delay is a parameter counted in clocks. One shared down-counter enforces them all, and the pins carry NOP while it runs. Only one bank is ever open, so the gap between ACTIVE commands to different banks is covered by the row-cycle wait. The states are:

- ST_POWERUP: inhibit during the power-up wait.
- ST_PRECHARGE_ALL: close all banks.
- ST_INIT_REFRESH: start-up refreshes, repeated.
- ST_LOAD_MODE: program the mode register.
- ST_IDLE: arbitrate between refresh and requests.
- ST_AUTO_REFRESH: periodic refresh.
- ST_ACTIVATE: open the row.
- ST_ACCESS: read or write with auto precharge, and acknowledge.
- ST_WAIT: count the delay, then go to the stored resume state.

The transitions are:

- POWERUP→PRECHARGE_ALL when the wait expires.
- Each command state goes to WAIT, with its successor stored as the resume state.
- INIT_REFRESH resumes to itself until all start-up refreshes are issued, then to LOAD_MODE.
- LOAD_MODE resumes to IDLE.
- IDLE→AUTO_REFRESH when a refresh is pending; otherwise IDLE→ACTIVATE when a request is valid.
- AUTO_REFRESH resumes to IDLE.
- ACTIVATE resumes to ACCESS.
- ACCESS resumes to IDLE.

Top module: `sdram_cmd_seq`

## Requirements
- R1: After reset, chip select stays high for at least T_POWERUP clocks, `init_done` stays low, and no request is served before start-up completes.
- R2: Start-up issues, in this order, PRECHARGE with A10 high, INIT_REFRESHES AUTO REFRESH commands, and LOAD MODE with BA=0, A12=0, A11..A0 = mode word (CAS latency in A6..A4, burst type A3=0, burst length A2..A0=000 for single beat). After that, `init_done` is high.
- R3: Commands are encoded as {cs_n,ras_n,cas_n,we_n}: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO REFRESH 0001, LOAD MODE 0000, inhibit 1111. No other code is driven.
- R4: A command following PRECHARGE comes at least T_RP clocks later. One following AUTO REFRESH comes at least T_RFC clocks later. One following LOAD MODE comes at least T_MRD clocks later.
- R5: ACTIVE drives BA = request bank and A = request row. READ/WRITE drives BA = bank, A9..A0 = column, A10 = 1 (auto precharge) and A12..A11 = 0. WRITE is used exactly when the request is a write.
- R6: READ/WRITE follows the ACTIVE of the same request directly, at least T_RCD clocks later.
- R7: Consecutive ACTIVEs are at least T_RC apart. ACTIVE or AUTO REFRESH comes at least T_WR+T_RP clocks after a WRITE and at least CAS_LAT+T_RP clocks after a READ.
- R8: After start-up, AUTO REFRESH repeats with a spacing of REFI clocks, give or take at most one access sequence.
- R9: A due refresh is served even while requests arrive back to back.
- R10: `req_ack` is high for exactly one clock per request, in the clock where that request's READ/WRITE is on the pins.
- R11: After the first command, chip select stays low, and clocks without a command carry NOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present; held with its fields until acknowledged |
| req_write | input | 1 | 1 = write, 0 = read |
| req_bank | input | 2 | Target bank |
| req_row | input | 13 | Target row |
| req_col | input | 10 | Target column |
| req_ack | output | 1 | Request's column command issued this clock |
| init_done | output | 1 | Start-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row/column/opcode address |

## Verification
The embedded assertions check the spacing rules on the pins. They take for granted that every timing parameter is at least 2 and that a requester keeps `req_valid` and its fields steady from assertion until `req_ack`. The bench holds each request's fields steady until it sees the acknowledge and drops `req_valid` in that same half-cycle. It runs with small timing values so that a sweep over all banks, both directions and the row and column extremes also crosses several refresh intervals, both with idle gaps and with requests arriving back to back.

// File: rtl/sdram_seq_pkg.sv
package sdram_seq_pkg;

    typedef enum logic [3:0] {
        ST_POWERUP,
        ST_PRECHARGE_ALL,
        ST_INIT_REFRESH,
        ST_LOAD_MODE,
        ST_IDLE,
        ST_AUTO_REFRESH,
        ST_ACTIVATE,
        ST_ACCESS,
        ST_WAIT
    } seq_state_t;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t CMD_INHIBIT = pin_cmd_t'(4'b1111);
    localparam pin_cmd_t CMD_NOP     = pin_cmd_t'(4'b0111);
    localparam pin_cmd_t CMD_ACTIVE  = pin_cmd_t'(4'b0011);
    localparam pin_cmd_t CMD_READ    = pin_cmd_t'(4'b0101);
    localparam pin_cmd_t CMD_WRITE   = pin_cmd_t'(4'b0100);
    localparam pin_cmd_t CMD_PRECHG  = pin_cmd_t'(4'b0010);
    localparam pin_cmd_t CMD_REFRESH = pin_cmd_t'(4'b0001);
    localparam pin_cmd_t CMD_LOADMR  = pin_cmd_t'(4'b0000);

endpackage

// File: rtl/sdram_seq_delay.sv
module sdram_seq_delay #(
    parameter int CW    = 16,
    parameter int START = 100
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= CW'(START);
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign done = (cnt <= CW'(1));
endmodule

// File: rtl/sdram_refresh_tick.sv
module sdram_refresh_tick #(
    parameter int INTERVAL = 975
) (
    input  logic clk,
    input  logic rst_n,
    input  logic served,
    output logic pending
);
    localparam int CW = $clog2(INTERVAL + 1);

    logic [CW-1:0] cnt;
    logic          tick;

    assign tick = (cnt == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt     <= CW'(INTERVAL - 1);
            pending <= 1'b0;
        end else begin
            cnt <= tick ? CW'(INTERVAL - 1) : cnt - 1'b1;
            if (tick)        pending <= 1'b1;
            else if (served) pending <= 1'b0;
        end
    end
endmodule

// File: rtl/sdram_cmd_seq.sv
module sdram_cmd_seq
    import sdram_seq_pkg::*;
#(
    parameter int BANK_W         = 2,
    parameter int ROW_W          = 13,
    parameter int COL_W          = 10,
    parameter int T_POWERUP      = 12500,
    parameter int T_RP           = 3,
    parameter int T_RFC          = 9,
    parameter int T_MRD          = 2,
    parameter int T_RCD          = 3,
    parameter int T_RC           = 9,
    parameter int T_WR           = 2,
    parameter int CAS_LAT        = 2,
    parameter int REFI           = 975,
    parameter int INIT_REFRESHES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    output logic              req_ack,
    output logic              init_done,
    output logic              sd_cs_n,
    output logic              sd_ras_n,
    output logic              sd_cas_n,
    output logic              sd_we_n,
    output logic [BANK_W-1:0] sd_ba,
    output logic [ROW_W-1:0]  sd_addr
);
    localparam int ADDR_W   = ROW_W;
    localparam int RD_END   = (T_RC - T_RCD > CAS_LAT + T_RP) ? T_RC - T_RCD : CAS_LAT + T_RP;
    localparam int WR_END   = (T_RC - T_RCD > T_WR + T_RP) ? T_RC - T_RCD : T_WR + T_RP;
    localparam int TW       = $clog2(T_POWERUP + T_RC + T_RFC + 4);
    localparam int RW       = $clog2(INIT_REFRESHES + 1);
    localparam logic [11:0] MODE_WORD = 12'(CAS_LAT << 4);

    seq_state_t state, state_n, resume, resume_n;
    pin_cmd_t   cmd;

    logic              tmr_load, tmr_done;
    logic [TW-1:0]     tmr_val;
    logic              ref_pending, ref_served;
    logic [RW-1:0]     init_left;
    logic              done_q;
    logic              lat_wr;
    logic [BANK_W-1:0] lat_bank;
    logic [ROW_W-1:0]  lat_row;
    logic [COL_W-1:0]  lat_col;

    sdram_seq_delay #(.CW(TW), .START(T_POWERUP + 1)) u_delay (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val), .done(tmr_done)
    );

    sdram_refresh_tick #(.INTERVAL(REFI)) u_refresh (
        .clk(clk), .rst_n(rst_n), .served(ref_served), .pending(ref_pending)
    );

    assign ref_served = (state == ST_AUTO_REFRESH);

    // Next-state: every command state issues for one clock, then counts its delay in ST_WAIT.
    always_comb begin
        state_n  = state;
        resume_n = resume;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state)
            ST_POWERUP:       if (tmr_done) state_n = ST_PRECHARGE_ALL;
            ST_PRECHARGE_ALL: begin
                state_n = ST_WAIT; resume_n = ST_INIT_REFRESH;
                tmr_load = 1'b1; tmr_val = TW'(T_RP - 1);
            end
            ST_INIT_REFRESH:  begin
                state_n  = ST_WAIT;
                resume_n = (init_left == RW'(1)) ? ST_LOAD_MODE : ST_INIT_REFRESH;
                tmr_load = 1'b1; tmr_val = TW'(T_RFC - 1);
            end
            ST_LOAD_MODE:     begin
                state_n = ST_WAIT; resume_n = ST_IDLE;
                tmr_load = 1'b1; tmr_val = TW'(T_MRD - 1);
            end
            ST_IDLE:          begin
                if (ref_pending)    state_n = ST_AUTO_REFRESH;
                else if (req_valid) state_n = ST_ACTIVATE;
            end
            ST_AUTO_REFRESH:  begin
                state_n = ST_WAIT; resume_n = ST_IDLE;
                tmr_load = 1'b1; tmr_val = TW'(T_RFC - 1);
            end
            ST_ACTIVATE:      begin
                state_n = ST_WAIT; resume_n = ST_ACCESS;
                tmr_load = 1'b1; tmr_val = TW'(T_RCD - 1);
            end
            ST_ACCESS:        begin
                state_n = ST_WAIT; resume_n = ST_IDLE;
                tmr_load = 1'b1; tmr_val = lat_wr ? TW'(WR_END - 1) : TW'(RD_END - 1);
            end
            ST_WAIT:          if (tmr_done) state_n = resume;
            default:          state_n = ST_POWERUP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_POWERUP;
            resume    <= ST_IDLE;
            init_left <= RW'(INIT_REFRESHES);
            done_q    <= 1'b0;
            lat_wr    <= 1'b0;
            lat_bank  <= '0;
            lat_row   <= '0;
            lat_col   <= '0;
        end else begin
            state  <= state_n;
            resume <= resume_n;
            if (state == ST_INIT_REFRESH) init_left <= init_left - 1'b1;
            if (state == ST_LOAD_MODE)    done_q    <= 1'b1;
            if (state == ST_IDLE && !ref_pending && req_valid) begin
                lat_wr   <= req_write;
                lat_bank <= req_bank;
                lat_row  <= req_row;
                lat_col  <= req_col;
            end
        end
    end

    // Pin outputs decoded from the current state.
    always_comb begin
        cmd     = CMD_NOP;
        sd_ba   = '0;
        sd_addr = '0;
        req_ack = 1'b0;
        unique case (state)
            ST_POWERUP:       cmd = CMD_INHIBIT;
            ST_PRECHARGE_ALL: begin cmd = CMD_PRECHG; sd_addr[10] = 1'b1; end
            ST_INIT_REFRESH,
            ST_AUTO_REFRESH:  cmd = CMD_REFRESH;
            ST_LOAD_MODE:     begin cmd = CMD_LOADMR; sd_addr = ADDR_W'(MODE_WORD); end
            ST_ACTIVATE:      begin cmd = CMD_ACTIVE; sd_ba = lat_bank; sd_addr = lat_row; end
            ST_ACCESS:        begin
                cmd         = lat_wr ? CMD_WRITE : CMD_READ;
                sd_ba       = lat_bank;
                sd_addr     = ADDR_W'(lat_col);
                sd_addr[10] = 1'b1;
                req_ack     = 1'b1;
            end
            default:          cmd = CMD_NOP;
        endcase
    end

    assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
    assign init_done = done_q;

    // Spacing monitors for the embedded properties.
    logic [15:0] since_act, since_ref;
    logic        seen_act, seen_ref;
    logic        is_col, is_cmd;

    assign is_col = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign is_cmd = !cmd.cs_n && (cmd != CMD_NOP);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            since_act <= '0; since_ref <= '0;
            seen_act  <= 1'b0; seen_ref <= 1'b0;
        end else begin
            since_act <= (cmd == CMD_ACTIVE) ? 16'd1 : (since_act == 16'hFFFF ? since_act : since_act + 1'b1);
            since_ref <= (cmd == CMD_REFRESH) ? 16'd1 : (since_ref == 16'hFFFF ? since_ref : since_ref + 1'b1);
            if (cmd == CMD_ACTIVE)  seen_act <= 1'b1;
            if (cmd == CMD_REFRESH) seen_ref <= 1'b1;
        end
    end

    AST_RCD_MET:   assert property (@(posedge clk) disable iff (!rst_n)
                       is_col |-> (seen_act && since_act >= 16'(T_RCD)));             // R6
    AST_RC_MET:    assert property (@(posedge clk) disable iff (!rst_n)
                       (cmd == CMD_ACTIVE && seen_act) |-> since_act >= 16'(T_RC));   // R7
    AST_AUTOPRE:   assert property (@(posedge clk) disable iff (!rst_n)
                       is_col |-> sd_addr[10]);                                       // R5
    AST_RFC_MET:   assert property (@(posedge clk) disable iff (!rst_n)
                       (is_cmd && seen_ref && cmd != CMD_REFRESH) |-> since_ref >= 16'(T_RFC)); // R4
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
                       req_ack |=> !req_ack);                                         // R10
endmodule

// File: tb/sdram_cmd_seq_test.sv
module sdram_cmd_seq_test;
    localparam int T_POWERUP = 16, T_RP = 3, T_RFC = 7, T_MRD = 2, T_RCD = 3;
    localparam int T_RC = 7, T_WR = 2, CAS_LAT = 2, REFI = 160, INIT_REF = 2;
    localparam int N = 32, NGAP = 12;
    localparam int SLACK = T_RC + T_WR + T_RP + CAS_LAT + 4;
    localparam logic [3:0] C_ACT = 4'b0011, C_RD = 4'b0101, C_WR = 4'b0100;
    localparam logic [3:0] C_PRE = 4'b0010, C_REF = 4'b0001, C_LMR = 4'b0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0;
    logic [1:0] req_bank = '0;
    logic [12:0] req_row = '0;
    logic [9:0] req_col = '0;
    logic req_ack, init_done, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0] sd_ba;
    logic [12:0] sd_addr;

    always #4 clk = ~clk;

    sdram_cmd_seq #(.T_POWERUP(T_POWERUP), .T_RP(T_RP), .T_RFC(T_RFC), .T_MRD(T_MRD),
        .T_RCD(T_RCD), .T_RC(T_RC), .T_WR(T_WR), .CAS_LAT(CAS_LAT), .REFI(REFI),
        .INIT_REFRESHES(INIT_REF)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_bank(req_bank), .req_row(req_row), .req_col(req_col), .req_ack(req_ack),
        .init_done(init_done), .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n),
        .sd_we_n(sd_we_n), .sd_ba(sd_ba), .sd_addr(sd_addr));

    int checks = 0, errors = 0;
    int nc = 0, inhibit_cnt = 0, log_n = 0, ack_cnt = 0;
    int sat_start = 0, sat_end = 0;
    logic [3:0]  l_code [0:1023];
    logic [12:0] l_addr [0:1023];
    logic [1:0]  l_ba   [0:1023];
    int          l_cyc  [0:1023];
    int e_bank [0:N-1], e_row [0:N-1], e_col [0:N-1];
    bit e_wr [0:N-1];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Pin monitor, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [3:0] code;
            code = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
            nc++;
            if (nc == 5) begin
                chk(sd_cs_n == 1'b1, "R1 cs_n during power-up", int'(sd_cs_n), 1);
                chk(init_done == 1'b0, "R1 init_done during power-up", int'(init_done), 0);
            end
            if (code[3] && log_n == 0) inhibit_cnt++;
            if (code[3] && log_n > 0) chk(1'b0, "R11 cs_n high after start", int'(code), 7);
            if (!code[3] && code != 4'b0111 && log_n < 1024) begin
                l_code[log_n] = code; l_addr[log_n] = sd_addr;
                l_ba[log_n] = sd_ba; l_cyc[log_n] = nc; log_n++;
            end
            if (req_ack || code == C_RD || code == C_WR) begin
                chk(req_ack && (code == C_RD || code == C_WR), "R10 ack with column command",
                    int'(req_ack), 1);
                if (req_ack) ack_cnt++;
            end
        end
    end

    task automatic issue(input int i);
        req_write = e_wr[i]; req_bank = 2'(e_bank[i]);
        req_row = 13'(e_row[i]); req_col = 10'(e_col[i]);
        req_valid = 1'b1;
        do @(negedge clk); while (!req_ack);
        req_valid = 1'b0;
    endtask

    task automatic analyse();
        int k = 0, last_act = -1, last_acc = -1, last_ref = -1, nref = 0, nsat = 0;
        bit last_wr = 0;
        chk(inhibit_cnt >= T_POWERUP, "R1 inhibit clocks", inhibit_cnt, T_POWERUP);
        chk(log_n >= 4, "R2 start-up command count", log_n, 4);
        if (log_n < 4) return;
        chk(l_code[0] == C_PRE && l_addr[0][10], "R2 precharge all first", int'(l_code[0]), int'(C_PRE));
        chk(l_code[1] == C_REF, "R2 first start-up refresh", int'(l_code[1]), int'(C_REF));
        chk(l_code[2] == C_REF, "R2 second start-up refresh", int'(l_code[2]), int'(C_REF));
        chk(l_code[3] == C_LMR && l_ba[3] == 2'd0, "R2 load mode", int'(l_code[3]), int'(C_LMR));
        chk(l_addr[3] == 13'(CAS_LAT * 16), "R2 mode word", int'(l_addr[3]), CAS_LAT * 16);
        chk(l_cyc[1] - l_cyc[0] >= T_RP, "R4 tRP after precharge", l_cyc[1] - l_cyc[0], T_RP);
        chk(l_cyc[2] - l_cyc[1] >= T_RFC, "R4 tRFC start-up", l_cyc[2] - l_cyc[1], T_RFC);
        chk(l_cyc[3] - l_cyc[2] >= T_RFC, "R4 tRFC before mode", l_cyc[3] - l_cyc[2], T_RFC);
        for (int j = 4; j < log_n; j++) begin
            int c, gap;
            c = l_cyc[j]; gap = c - l_cyc[j-1];
            if (l_code[j-1] == C_REF) chk(gap >= T_RFC, "R4 tRFC after refresh", gap, T_RFC);
            if (l_code[j-1] == C_LMR) chk(gap >= T_MRD, "R4 tMRD after mode", gap, T_MRD);
            if (last_acc >= 0 && (l_code[j] == C_ACT || l_code[j] == C_REF))
                chk(c - last_acc >= (last_wr ? T_WR + T_RP : CAS_LAT + T_RP), "R7 recovery after access",
                    c - last_acc, last_wr ? T_WR + T_RP : CAS_LAT + T_RP);
            if (last_act >= 0 && (l_code[j] == C_ACT || l_code[j] == C_REF))
                chk(c - last_act >= T_RC, "R7 row cycle", c - last_act, T_RC);
            if (l_code[j] == C_ACT) begin
                if (k < N) begin
                    chk(int'(l_ba[j]) == e_bank[k], "R5 active bank", int'(l_ba[j]), e_bank[k]);
                    chk(int'(l_addr[j]) == e_row[k], "R5 active row", int'(l_addr[j]), e_row[k]);
                end
                last_act = c;
            end else if (l_code[j] == C_RD || l_code[j] == C_WR) begin
                chk(l_code[j-1] == C_ACT, "R6 column after its active", int'(l_code[j-1]), int'(C_ACT));
                chk(c - last_act >= T_RCD, "R6 tRCD", c - last_act, T_RCD);
                if (k < N) begin
                    chk((l_code[j] == C_WR) == e_wr[k], "R5 direction", int'(l_code[j]),
                        e_wr[k] ? int'(C_WR) : int'(C_RD));
                    chk(l_addr[j] == {2'b00, 1'b1, 10'(e_col[k])} && int'(l_ba[j]) == e_bank[k],
                        "R5 column address", int'(l_addr[j]), 1024 + e_col[k]);
                end
                k++; last_acc = c; last_wr = (l_code[j] == C_WR);
            end else if (l_code[j] == C_REF) begin
                if (last_ref >= 0)
                    chk(c - last_ref >= REFI - SLACK && c - last_ref <= REFI + SLACK,
                        "R8 refresh spacing", c - last_ref, REFI);
                if (c >= sat_start && c <= sat_end) nsat++;
                last_ref = c; nref++;
            end else begin
                chk(1'b0, "R3 unexpected command code", int'(l_code[j]), int'(C_ACT));
            end
        end
        chk(k == N, "R10 column commands issued", k, N);
        chk(ack_cnt == N, "R10 acknowledges", ack_cnt, N);
        chk(nsat >= 1, "R9 refresh during back-to-back requests", nsat, 1);
        chk(nref >= (nc - l_cyc[3]) / REFI - 1, "R8 refresh count", nref, (nc - l_cyc[3]) / REFI - 1);
        chk(init_done == 1'b1, "R2 init_done after start-up", int'(init_done), 1);
    endtask

    initial begin
        for (int i = 0; i < N; i++) begin
            e_bank[i] = i % 4;
            e_wr[i]   = ((i / 4) % 2) == 1;
            e_row[i]  = (i == 1) ? 8191 : (i * 977 + 5) % 8192;
            e_col[i]  = (i == 2) ? 1023 : (i * 131) % 1024;
        end
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        // R1: request raised during power-up must wait for start-up.
        for (int i = 0; i < N; i++) begin
            if (i == NGAP) sat_start = nc;
            issue(i);
            if (i < NGAP) repeat ((i % 3) * 17) @(negedge clk);
        end
        sat_end = nc;
        repeat (400) @(negedge clk);
        analyse();
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(1'b0, "watchdog expired", nc, 0);
        summary();
        $finish;
    end
endmodule